// File: doc/BRIEF.md
# Voting Memory Access Proxy

This block connects a core that carries every value as four replicated 64-bit copies to a memory that stores a single copy. A request arrives with four copies of its address and, for stores, four copies of its write data. The proxy votes across the copies to mask one or two corrupted lanes, then issues a single ordinary access to memory using the voted values. A corrupted address therefore never reaches memory unchecked. Memory integrity is protected by other means and is not handled here.

On a load, the single word returned by memory is copied into all four lanes of the response. On a store, the response carries no data and is raised only once the memory port has taken the write. If the copies split evenly or all differ, the request is aborted with an error response and memory is left untouched. Every response reports whether any lane was outvoted. The proxy serves one request at a time.

Top module: `vmp_proxy`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_valid is 0.
- R2: Lane i of req_addr and req_wdata occupies bits [i*64 +: 64]. When three or four address lanes agree, the memory access uses that value, and rsp_fixed is 1 exactly when some lane differed.
- R3: When two address lanes agree and the other two each hold a different value, the agreeing value is used and rsp_fixed is 1.
- R4: When the address lanes split two against two, or all four differ, the response has rsp_error=1, rsp_fixed=0 and all-zero rsp_rdata, and no memory access is made.
- R5: A store votes its data lanes by the same rules as R2 to R4; rsp_fixed is 1 if either the address or the data was corrected, and a data vote with no majority aborts the store as in R4.
- R6: A load ignores the data lanes: a load whose data lanes have no majority completes normally with rsp_fixed decided by the address alone.
- R7: Each request that is not aborted makes exactly one memory access; mem_valid with mem_addr, mem_wdata and mem_write stays stable until mem_ready is seen.
- R8: A load response has rsp_error=0 and carries the word from mem_rdata (taken when mem_rvalid is 1) in all four lanes of rsp_rdata.
- R9: A store response has all-zero rsp_rdata and is raised only after mem_valid and mem_ready were both high.
- R10: req_ready is 0 from the cycle after a request is accepted until the cycle after the response handshake.
- R11: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_rdata, rsp_error and rsp_fixed hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Proxy idle and accepting |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 256 | Four address copies |
| req_wdata | input | 256 | Four write data copies |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rdata | output | 256 | Load data in four lanes, zero otherwise |
| rsp_error | output | 1 | Request aborted, no majority |
| rsp_fixed | output | 1 | At least one lane was outvoted |
| mem_valid | output | 1 | Memory access requested |
| mem_ready | input | 1 | Memory takes the access |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 64 | Voted address |
| mem_wdata | output | 64 | Voted write data |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 64 | Read data word |

## Verification
On every cycle the assertions watch the handshake rules: held memory and response signals under back-pressure, the closed request port while busy, a store acknowledged only after the write was taken, an abort that follows acceptance with no memory access in between, and that any vote result is backed by at least two lanes. Which value the vote picks for each lane pattern, the corrected flag, the ignored data lanes of a load and the four-fold copy of read data are shown only by the bench's scenarios, which compare memory traffic and responses with values worked out per pattern.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
  localparam int unsigned VMP_LANES = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } vmp_state_e;
endpackage

// File: rtl/vmp_rst_sync.sv
module vmp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/vmp_voter.sv
module vmp_voter
  import vmp_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [VMP_LANES*W-1:0] lanes_i,
  output logic [W-1:0]           value_o,
  output logic                   ok_o,
  output logic                   fixed_o
);
  localparam int unsigned SELW = $clog2(VMP_LANES);
  localparam int unsigned CNTW = $clog2(VMP_LANES);

  logic [W-1:0]           lane [VMP_LANES];
  logic [VMP_LANES-1:0]   eq   [VMP_LANES];
  logic [CNTW-1:0]        cnt  [VMP_LANES];
  logic [SELW-1:0]        maj_sel, pair_sel;
  logic                   has_maj;
  logic [CNTW:0]          singles;
  logic                   all_same;

  for (genvar gi = 0; gi < VMP_LANES; gi++) begin : g_unpack
    assign lane[gi] = lanes_i[gi*W +: W];
  end

  always_comb begin
    for (int i = 0; i < VMP_LANES; i++) begin
      for (int j = 0; j < VMP_LANES; j++) begin
        eq[i][j] = (i != j) && (lane[i] == lane[j]);
      end
      cnt[i] = CNTW'($countones(eq[i]));
    end
  end

  // Lowest lane backed by two others wins; otherwise a lone agreeing pair.
  always_comb begin
    has_maj  = 1'b0;
    maj_sel  = '0;
    pair_sel = '0;
    singles  = '0;
    all_same = 1'b1;
    for (int i = VMP_LANES - 1; i >= 0; i--) begin
      if (cnt[i] >= CNTW'(2)) begin
        has_maj = 1'b1;
        maj_sel = SELW'(i);
      end
      if (cnt[i] == CNTW'(1)) begin
        singles  = singles + 1'b1;
        pair_sel = SELW'(i);
      end
      if (cnt[i] != CNTW'(VMP_LANES - 1)) all_same = 1'b0;
    end
  end

  assign ok_o    = has_maj || (singles == (CNTW+1)'(2));
  assign value_o = has_maj ? lane[maj_sel] : lane[pair_sel];
  assign fixed_o = ok_o && !all_same;

  // R2/R3: whatever value is reported must be held by at least two lanes.
  logic [VMP_LANES-1:0] backs;
  always_comb begin
    for (int i = 0; i < VMP_LANES; i++) backs[i] = (lane[i] == value_o);
    if (ok_o) begin
      assert_vote_backed_R3: assert ($countones(backs) >= 2);
    end
  end
endmodule

// File: rtl/vmp_ctrl.sv
module vmp_ctrl
  import vmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic addr_ok,
  input  logic addr_fixed,
  input  logic data_ok,
  input  logic data_fixed,
  input  logic mem_ready,
  input  logic mem_rvalid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic rdata_en,
  output logic mem_valid,
  output logic wr_q,
  output logic rsp_valid,
  output logic err_q,
  output logic fix_q
);
  vmp_state_e state_q, state_d;
  logic       vote_bad, err_d, fix_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_valid = (state_q == ST_ISSUE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rdata_en  = (state_q == ST_WAIT) && mem_rvalid;

  assign vote_bad = !addr_ok || (req_write && !data_ok);
  assign err_d    = vote_bad;
  assign fix_d    = !vote_bad && (addr_fixed || (req_write && data_fixed));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)     state_d = vote_bad ? ST_RESP : ST_ISSUE;
      ST_ISSUE: if (mem_ready)  state_d = wr_q ? ST_RESP : ST_WAIT;
      ST_WAIT:  if (mem_rvalid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      err_q <= 1'b0;
      fix_q <= 1'b0;
    end else if (accept) begin
      wr_q  <= req_write;
      err_q <= err_d;
      fix_q <= fix_d;
    end
  end

  assert_store_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && wr_q && !err_q) |-> $past(mem_valid && mem_ready));

  assert_abort_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && err_q) |-> $past(req_valid && req_ready));
endmodule

// File: rtl/vmp_proxy.sv
module vmp_proxy
  import vmp_pkg::*;
#(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [VMP_LANES*AW-1:0] req_addr,
  input  logic [VMP_LANES*DW-1:0] req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [VMP_LANES*DW-1:0] rsp_rdata,
  output logic                   rsp_error,
  output logic                   rsp_fixed,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_write,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_rvalid,
  input  logic [DW-1:0]          mem_rdata
);
  logic          rst_n_s;
  logic [AW-1:0] addr_v;
  logic [DW-1:0] data_v;
  logic          addr_ok, addr_fixed, data_ok, data_fixed;
  logic          accept, rdata_en, wr_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic          rdata_ld;

  vmp_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vmp_voter #(.W(AW)) u_vote_addr (
    .lanes_i (req_addr),
    .value_o (addr_v),
    .ok_o    (addr_ok),
    .fixed_o (addr_fixed)
  );

  vmp_voter #(.W(DW)) u_vote_data (
    .lanes_i (req_wdata),
    .value_o (data_v),
    .ok_o    (data_ok),
    .fixed_o (data_fixed)
  );

  vmp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .addr_ok    (addr_ok),
    .addr_fixed (addr_fixed),
    .data_ok    (data_ok),
    .data_fixed (data_fixed),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .accept     (accept),
    .rdata_en   (rdata_en),
    .mem_valid  (mem_valid),
    .wr_q       (wr_q),
    .rsp_valid  (rsp_valid),
    .err_q      (rsp_error),
    .fix_q      (rsp_fixed)
  );

  // Next-state of the datapath: voted values on accept, read word on return.
  always_comb begin
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    rdata_ld = accept || rdata_en;
    if (accept) begin
      addr_d  = addr_v;
      wdata_d = req_write ? data_v : '0;
      rdata_d = '0;
    end else if (rdata_en) begin
      rdata_d = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      rdata_q <= '0;
    else if (rdata_ld) rdata_q <= rdata_d;
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_write = wr_q;

  for (genvar gl = 0; gl < VMP_LANES; gl++) begin : g_bcast
    assign rsp_rdata[gl*DW +: DW] = rdata_q;
  end

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_write)));

  assert_busy_closed_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)
                                   && $stable(rsp_error) && $stable(rsp_fixed)));
endmodule

// File: tb/vmp_proxy_test.sv
`timescale 1ns/1ps
module vmp_proxy_test;
  localparam logic [63:0] K  = 64'h5A5A_0000_F00D_0000;
  localparam logic [63:0] A  = 64'h0000_0000_0000_1000;
  localparam logic [63:0] B  = 64'h0000_0000_0000_1008;
  localparam logic [63:0] C  = 64'h8000_0000_0000_1000;
  localparam logic [63:0] E  = 64'h0000_0000_0000_2040;
  localparam logic [63:0] D0 = 64'hDEAD_BEEF_0123_4567;
  localparam logic [63:0] D1 = 64'hDEAD_BEEF_0123_4566;
  localparam logic [63:0] D2 = 64'h1111_2222_3333_4444;

  typedef struct packed {
    logic         wr;
    logic [255:0] a;
    logic [255:0] d;
    logic         err;
    logic         fix;
    logic [63:0]  ea;
    logic [63:0]  ed;
    logic [7:0]   rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, {A,A,A,A}, {D0,D0,D0,D0}, 1'b0, 1'b0, A, 64'd0, 8'd2}, // R2 clean load
    '{1'b0, {A,B,A,A}, {D0,D0,D0,D0}, 1'b0, 1'b1, A, 64'd0, 8'd2}, // R2 one bad lane
    '{1'b0, {E,E,E,C}, {D0,D0,D0,D0}, 1'b0, 1'b1, E, 64'd0, 8'd2}, // R2 lane0 bad
    '{1'b0, {A,B,C,A}, {D0,D0,D0,D0}, 1'b0, 1'b1, A, 64'd0, 8'd3}, // R3 2-1-1
    '{1'b0, {A,A,B,B}, {D0,D0,D0,D0}, 1'b1, 1'b0, A, 64'd0, 8'd4}, // R4 tie
    '{1'b0, {A,B,C,E}, {D0,D0,D0,D0}, 1'b1, 1'b0, A, 64'd0, 8'd4}, // R4 all differ
    '{1'b1, {E,E,E,E}, {D0,D0,D0,D0}, 1'b0, 1'b0, E, D0,    8'd5}, // R5 clean store
    '{1'b1, {E,E,E,E}, {D0,D0,D1,D0}, 1'b0, 1'b1, E, D0,    8'd5}, // R5 data fix
    '{1'b1, {E,E,E,E}, {D0,D1,D0,D1}, 1'b1, 1'b0, E, 64'd0, 8'd5}, // R5 data tie
    '{1'b0, {B,B,B,B}, {D0,D1,D2,D1}, 1'b0, 1'b0, B, 64'd0, 8'd6}, // R6 data ignored
    '{1'b1, {C,A,B,C}, {D2,D2,D2,D2}, 1'b0, 1'b1, C, D2,    8'd3}  // R3 store addr
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write;
  logic [255:0] req_addr, req_wdata;
  logic         rsp_valid, rsp_ready, rsp_error, rsp_fixed;
  logic [255:0] rsp_rdata;
  logic         mem_valid, mem_ready, mem_write;
  logic [63:0]  mem_addr, mem_wdata;
  logic         mem_rvalid;
  logic [63:0]  mem_rdata;

  int compared = 0;
  int mismatched = 0;
  int mem_delay = 0;
  int wcnt = 0;
  int acc_cnt = 0;
  logic [63:0] last_addr, last_data;
  logic        last_wr;

  always #2 clk = ~clk;

  vmp_proxy uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_error(rsp_error), .rsp_fixed(rsp_fixed),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Memory model: ready after mem_delay stalled cycles, read word one cycle later.
  assign mem_ready = (wcnt >= mem_delay);
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      wcnt      <= 0;
      acc_cnt   <= acc_cnt + 1;
      last_addr <= mem_addr;
      last_data <= mem_wdata;
      last_wr   <= mem_write;
      if (!mem_write) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_addr ^ K;
      end
    end else if (mem_valid) begin
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [255:0] act,
                     input logic [255:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v, input int hold);
    int base;
    int n;
    string rq;
    logic [255:0] exp_rd;
    rq = $sformatf("R%0d", v.rq);
    exp_rd = (!v.err && !v.wr) ? {4{v.ea ^ K}} : 256'd0;
    @(negedge clk);
    base = acc_cnt;
    chk(req_ready == 1'b1, "R10 idle ready", 256'(req_ready), 256'd1);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.a; req_wdata = v.d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 50) begin
      chk(req_ready == 1'b0, "R10 busy", 256'(req_ready), 256'd0);
      if (mem_valid && !mem_ready)
        chk(mem_addr == v.ea, "R7 held addr", 256'(mem_addr), 256'(v.ea));
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, {rq, " response"}, 256'(rsp_valid), 256'd1);
    if (v.wr && !v.err)  // R9: acknowledge only after memory took the write
      chk(acc_cnt == base + 1, "R9 ack after accept", 256'(acc_cnt - base), 256'd1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == exp_rd, "R11 hold", rsp_rdata, exp_rd);
    end
    chk(rsp_error == v.err, {rq, " error"}, 256'(rsp_error), 256'(v.err));
    chk(rsp_fixed == v.fix, {rq, " fixed"}, 256'(rsp_fixed), 256'(v.fix));
    chk(rsp_rdata == exp_rd, {rq, " R8 rdata"}, rsp_rdata, exp_rd);
    chk(acc_cnt - base == (v.err ? 0 : 1), {rq, " R7 access count"},
        256'(acc_cnt - base), 256'(v.err ? 0 : 1));
    if (!v.err) begin
      chk(last_addr == v.ea, {rq, " mem addr"}, 256'(last_addr), 256'(v.ea));
      chk(last_wr == v.wr, {rq, " mem write"}, 256'(last_wr), 256'(v.wr));
      if (v.wr) chk(last_data == v.ed, {rq, " R5 mem data"}, 256'(last_data), 256'(v.ed));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 reopened", 256'({rsp_valid, req_ready}), 256'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 req_ready", 256'(req_ready), 256'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 256'(rsp_valid), 256'd0);
    chk(mem_valid == 1'b0, "R1 mem_valid", 256'(mem_valid), 256'd0);

    for (int i = 0; i < NV; i++) run_txn(TBL[i], 0);

    // Directed: memory stalls and response back-pressure (R7, R9, R11)
    mem_delay = 3;
    run_txn(TBL[7], 3);
    run_txn(TBL[3], 2);
    run_txn(TBL[4], 2);
    mem_delay = 0;
    // Back-to-back after stalls
    run_txn(TBL[0], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule